// File: doc/BRIEF.md
# Memory Controller Interrupt Status Unit

This block gathers six single-cycle event pulses from a memory controller into a sticky interrupt status register. Each pulse sets its own flag. The flag stays set until software clears it by writing a one to the matching bit of the acknowledge register. The top bit of the status register is a live summary: it is high whenever any event flag is set.

A 7-bit mask register gates which status bits can drive the single interrupt line. A mask bit of one suppresses that bit, and the summary bit counts as an interrupt source of its own. A simple register port gives access to the mask, the acknowledge and the status registers.

The unit keeps a first out-of-range access apart from repeated ones. If an out-of-range pulse arrives while the first out-of-range flag is already set, the multiple-access flag is also raised.

Top module: `mc_irq_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the status register reads 0, the mask register reads 0 and `irq_o` is low.
- R2: A pulse on `evt_i[k]` (k = 0 single out-of-range, 1 multiple out-of-range, 2 init done, 3 page crossing, 4 conflicting modes, 5 DLL unlock) sets status bit k at the next clock edge. The bit stays set until it is acknowledged.
- R3: A write to address 1 (acknowledge) clears each status bit k in 0..5 whose data bit k is 1. Bits whose data bit is 0 are left unchanged.
- R4: When an event and an acknowledge of the same bit occur in the same cycle, the bit ends up set.
- R5: A pulse on `evt_i[0]` while status bit 0 is already set also sets status bit 1. A first such pulse, with bit 0 clear, sets only bit 0.
- R6: Status bit 6 reads as the OR of status bits 0 to 5.
- R7: A read of address 1 (acknowledge) always returns 0.
- R8: The status register (address 2) is read-only: a write to address 2 has no effect on it.
- R9: The mask register at address 0 (bits 6:0) is readable and writable. `irq_o` is the OR over all 7 status bits ANDed with the inverted mask.
- R10: When mask bit 6 is 0, `irq_o` stays high whenever any event flag is set, even if the lower mask bits cover that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 6 | Event pulses, one per status flag |
| reg_sel_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | 0 mask, 1 acknowledge, 2 status |
| reg_wdata_i | input | 7 | Write data |
| reg_rdata_o | output | 7 | Read data (combinational, zero when no read) |
| irq_o | output | 1 | Interrupt output |

## Verification
Every event input is pulsed on its own from a clear register. This shows that each input reaches only its own bit, and that a lone out-of-range pulse does not raise the multiple-access flag. Paired pulses followed by partial and all-zero acknowledge writes separate bits that are cleared from bits that are merely held. A pulse that coincides with its own acknowledge confirms that the set wins. A sweep of mask patterns, both with and without the summary bit masked, separates per-bit masking from the effect of the summary bit on the interrupt line.

// File: rtl/mc_irq_pkg.sv
package mc_irq_pkg;
  localparam int NUM_EVT = 6;
  localparam int STAT_W  = NUM_EVT + 1;
  localparam int ADDR_W  = 2;
  localparam int IDX_OOR_ONE   = 0;
  localparam int IDX_OOR_MANY  = 1;
  localparam int IDX_SUMMARY   = NUM_EVT;

  typedef enum logic [ADDR_W-1:0] {
    ADR_MASK   = 2'd0,
    ADR_ACK    = 2'd1,
    ADR_STATUS = 2'd2,
    ADR_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/mc_irq_rst_sync.sv
module mc_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mc_irq_flags.sv
module mc_irq_flags
  import mc_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] ack_i,
  output logic [STAT_W-1:0]  status_o
);
  logic [NUM_EVT-1:0] flags_q;
  logic [NUM_EVT-1:0] flags_d;
  logic [NUM_EVT-1:0] set_vec;
  logic               flags_en;

  // Per-bit set sources; the repeated out-of-range flag has an extra source.
  for (genvar k = 0; k < NUM_EVT; k++) begin : g_set
    if (k == IDX_OOR_MANY) begin : g_many
      assign set_vec[k] = evt_i[k] | (evt_i[IDX_OOR_ONE] & flags_q[IDX_OOR_ONE]);
    end else begin : g_plain
      assign set_vec[k] = evt_i[k];
    end
  end

  always_comb begin
    flags_en = (|set_vec) | (|ack_i);
    flags_d  = (flags_q & ~ack_i) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign status_o = {|flags_q, flags_q};

  localparam logic [NUM_EVT-1:0] PLAIN_MASK = ~(NUM_EVT'(1) << IDX_OOR_MANY);

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_o[NUM_EVT-1:0] & $past(evt_i)) == $past(evt_i))) // R2
    else $error("event did not set its flag");

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i == '0) |=> ((status_o[NUM_EVT-1:0] & $past(status_o[NUM_EVT-1:0])) == $past(status_o[NUM_EVT-1:0]))) // R2
    else $error("flag dropped without acknowledge");

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_i & ~evt_i & PLAIN_MASK)) |=> ((status_o[NUM_EVT-1:0] & $past(ack_i & ~evt_i & PLAIN_MASK)) == '0)) // R3
    else $error("acknowledged flag not cleared");

  AST_REPEAT_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[IDX_OOR_ONE] && status_o[IDX_OOR_ONE]) |=> status_o[IDX_OOR_MANY]) // R5
    else $error("repeat out-of-range missed");
endmodule

// File: rtl/mc_irq_regport.sv
module mc_irq_regport
  import mc_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [STAT_W-1:0]  wdata_i,
  input  logic [STAT_W-1:0]  status_i,
  output logic [STAT_W-1:0]  rdata_o,
  output logic [STAT_W-1:0]  mask_o,
  output logic [NUM_EVT-1:0] ack_o
);
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] mask_d;
  logic              mask_en;
  logic              wr_acc;
  logic              rd_acc;

  always_comb begin
    wr_acc  = sel_i & wr_i;
    rd_acc  = sel_i & ~wr_i;
    mask_en = wr_acc & (addr_i == ADR_MASK);
    mask_d  = wdata_i;
    ack_o   = (wr_acc && addr_i == ADR_ACK) ? wdata_i[NUM_EVT-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_acc) begin
      unique case (reg_addr_e'(addr_i))
        ADR_MASK:   rdata_o = mask_q;
        ADR_STATUS: rdata_o = status_i;
        ADR_ACK:    rdata_o = '0;
        ADR_SPARE:  rdata_o = '0;
      endcase
    end
  end

  assign mask_o = mask_q;

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && addr_i == ADR_ACK) |-> (rdata_o == '0)) // R7
    else $error("acknowledge read not zero");

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acc && addr_i == ADR_MASK) |=> $stable(mask_o)) // R9
    else $error("mask changed without write");
endmodule

// File: rtl/mc_irq_combine.sv
module mc_irq_combine
  import mc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic              irq_o
);
  logic [STAT_W-1:0] live;

  always_comb begin
    live  = status_i & ~mask_i;
    irq_o = |live;
  end

  AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i[NUM_EVT-1:0] == '0) |-> !irq_o) // R9
    else $error("irq without event");

  AST_SUMMARY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_i[IDX_SUMMARY] && (|status_i[NUM_EVT-1:0])) |-> irq_o) // R10
    else $error("summary bit failed to raise irq");

  AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (!rst_n)
    status_i[IDX_SUMMARY] == (|status_i[NUM_EVT-1:0])) // R6
    else $error("summary bit mismatch");
endmodule

// File: rtl/mc_irq_unit.sv
module mc_irq_unit
  import mc_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               reg_sel_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [STAT_W-1:0]  reg_wdata_i,
  output logic [STAT_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  logic               rst_sync_n;
  logic [STAT_W-1:0]  status;
  logic [STAT_W-1:0]  mask;
  logic [NUM_EVT-1:0] ack;

  mc_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mc_irq_flags u_flags (
    .clk(clk), .rst_n(rst_sync_n), .evt_i(evt_i), .ack_i(ack), .status_o(status)
  );

  mc_irq_regport u_regs (
    .clk(clk), .rst_n(rst_sync_n), .sel_i(reg_sel_i), .wr_i(reg_wr_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .status_i(status),
    .rdata_o(reg_rdata_o), .mask_o(mask), .ack_o(ack)
  );

  mc_irq_combine u_comb (
    .clk(clk), .rst_n(rst_sync_n), .status_i(status), .mask_i(mask), .irq_o(irq_o)
  );
endmodule

// File: tb/mc_irq_unit_bench.sv
module mc_irq_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] evt;
  logic       sel, wr;
  logic [1:0] addr;
  logic [6:0] wdata;
  logic [6:0] rdata;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_irq_unit u_mc_irq_unit (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_sel_i(sel), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive events and an optional acknowledge together for one clock edge.
  task automatic drive(logic [5:0] e, bit do_ack, logic [6:0] ackv);
    @(negedge clk);
    evt = e;
    if (do_ack) begin sel = 1; wr = 1; addr = 2'd1; wdata = ackv; end
    @(negedge clk);
    evt = '0; sel = 0; wr = 0;
  endtask

  task automatic reg_write(logic [1:0] a, logic [6:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [6:0] d);
    sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    sel = 0;
  endtask

  task automatic expect_status(string req, logic [6:0] exp);
    logic [6:0] d;
    reg_read(2'd2, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    logic [6:0] d;
    rst_n = 0; evt = '0; sel = 0; wr = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    expect_status("R1 status in reset", 7'h00);
    reg_read(2'd0, d); check("R1 mask in reset", d, 0);
    check("R1 irq in reset", irq, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    expect_status("R1 status after reset", 7'h00);
    check("R1 irq after reset", irq, 0);
  endtask

  task automatic t_each_event();
    for (int k = 0; k < 6; k++) begin
      drive(6'(1 << k), 0, '0);
      expect_status($sformatf("R2 event %0d alone (R5 R6)", k), 7'(1 << k) | 7'h40);
      check($sformatf("R9 irq event %0d", k), irq, 1);
      reg_write(2'd1, 7'h3F);
      expect_status("R3 ack all", 7'h00);
      check("R9 irq after ack", irq, 0);
    end
  endtask

  task automatic t_sticky();
    drive(6'h04, 0, '0);
    repeat (5) @(negedge clk);
    expect_status("R2 sticky", 7'h44);
    reg_write(2'd1, 7'h3F);
  endtask

  task automatic t_partial_ack();
    logic [6:0] d;
    drive(6'h0C, 0, '0);
    reg_write(2'd1, 7'h04);
    expect_status("R3 partial ack", 7'h48);
    reg_write(2'd1, 7'h00);
    expect_status("R3 zero ack", 7'h48);
    reg_read(2'd1, d); check("R7 ack reads zero", d, 0);
    reg_write(2'd1, 7'h08);
    expect_status("R6 summary drops", 7'h00);
  endtask

  task automatic t_set_wins();
    drive(6'h10, 1, 7'h10);
    expect_status("R4 set wins", 7'h50);
    drive(6'h00, 1, 7'h10);
    expect_status("R4 later ack", 7'h00);
  endtask

  task automatic t_repeat_oor();
    drive(6'h01, 0, '0);
    expect_status("R5 first", 7'h41);
    drive(6'h01, 0, '0);
    expect_status("R5 repeat", 7'h43);
    reg_write(2'd1, 7'h3F);
  endtask

  task automatic t_status_ro();
    drive(6'h20, 0, '0);
    reg_write(2'd2, 7'h00);
    expect_status("R8 write ignored (set)", 7'h60);
    reg_write(2'd1, 7'h3F);
    reg_write(2'd2, 7'h7F);
    expect_status("R8 write ignored (clear)", 7'h00);
  endtask

  task automatic t_mask();
    logic [6:0] d;
    drive(6'h08, 0, '0);
    reg_write(2'd0, 7'h08);
    check("R10 summary keeps irq", irq, 1);
    reg_write(2'd0, 7'h48);
    reg_read(2'd0, d); check("R9 mask readback", d, 7'h48);
    check("R9 all masked", irq, 0);
    reg_write(2'd0, 7'h40);
    check("R9 bit unmasked", irq, 1);
    reg_write(2'd1, 7'h3F);
    reg_write(2'd0, 7'h7F);
    drive(6'h3F, 0, '0);
    check("R9 full mask", irq, 0);
    expect_status("R2 all events", 7'h7F);
    reg_write(2'd0, 7'h00);
    check("R9 mask cleared", irq, 1);
    reg_write(2'd1, 7'h3F);
  endtask

  initial begin
    t_reset();
    t_each_event();
    t_sticky();
    t_partial_ack();
    t_set_wins();
    t_repeat_oor();
    t_status_ro();
    t_mask();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule